// File: doc/BRIEF.md
# Framed Serial Command Decoder for a Line-Scan Sensor

This block is the device-side command interpreter of a line-scan image sensor that is driven over a three-wire clocked serial link (clock, data in, data out). Each character on the data-in line is framed the way an asynchronous serial port frames it: a low start bit, eight data bits least significant first, and a high stop bit. The only difference is that every bit is taken on a rising edge of the link clock. The decoder finds characters in the bit stream and turns them into commands. Most commands are one byte. A register write is two bytes: the first carries the register address and the second carries the data.

Action commands produce one-cycle pulses for the pixel sequencer: reset, start integration, sample, read out and abort read. Two combined opcodes raise several of these pulses in the same cycle. The block holds a small register file, read continuously by the analog front end: one signed offset and one gain per pixel zone, plus a mode word. A register read command sends the stored value back on the data-out line in the same framing. A break character (all-zero data with a low stop slot) brings the byte tracking back to a known state.

Top module: `scan_cmd_decoder`

## Requirements
- R1: A character is one start bit of 0, eight data bits with the least significant bit first, and a stop bit. Every bit is sampled on a rising edge of `sclk`. If the start bit is sampled at rising edge n, the decoded command takes effect at rising edge n+10, and its outputs are visible from that edge on.
- R2: The opcodes 0x1B, 0x08, 0x10, 0x02 and 0x19 each raise exactly one pulse, for exactly one cycle. The pulses are `act_reset`, `act_start`, `act_sample`, `act_read` and `act_abort`, in that order of opcodes.
- R3: Opcode 0x12 raises `act_sample` and `act_read` in the same cycle. Opcode 0x16 raises `act_sample`, `act_read` and `act_start` in the same cycle.
- R4: A byte that is neither an action opcode nor matches a register pattern raises no pulse and changes no register.
- R5: A byte whose bits [7:5] are 010 starts a register write. Its bits [4:0] give the address, and the next character is the data. The new value is on the register outputs from the decode edge of the data character. Addresses 0, 2 and 4 are the offsets of zones 0, 1 and 2. Addresses 1, 3 and 5 are the gains of the same zones. Address 0x1F is the mode register. Zone z occupies bits [8z+7:8z] of `zone_ofs` and bits [5z+4:5z] of `zone_gain`.
- R6: A gain stores data bits [4:0] and the mode register stores data bits [3:0]. When these registers are read back, the unused upper bits are 0.
- R7: A write to any other address changes no register, and a read of any other address returns 0x00.
- R8: A byte whose bits [7:5] are 011 is a register read of address bits [4:0], and it raises no pulse. Call its decode edge E. The start bit of the answer is driven on `sdout` at the falling edge after rising edge E+4. The eight data bits follow, least significant first, then a stop bit of 1, one bit per clock. `sdout` then stays at 1.
- R9: A break character (data 0x00 with the stop slot sampled 0) discards a half-received register write. The receiver then waits for `sdin` to return high, and the next character is taken as a command.
- R10: A character with nonzero data and a low stop slot is discarded without any effect, and the receiver waits for `sdin` to return high.
- R11: After `rst_n` is low, all registers read 0, all pulses are low and `sdout` is 1.
- R12: The reset opcode 0x1B leaves the register file unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Link clock. Bits are sampled on its rising edge; `sdout` changes on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdin | input | 1 | Serial command input, idles high |
| sdout | output | 1 | Serial register readback, idles high |
| act_reset | output | 1 | One-cycle reset request to the sequencer |
| act_start | output | 1 | One-cycle start-integration request |
| act_sample | output | 1 | One-cycle sample request |
| act_read | output | 1 | One-cycle pixel readout request |
| act_abort | output | 1 | One-cycle abort-readout request |
| zone_ofs | output | 24 | Signed offsets, zone 0 in the low byte |
| zone_gain | output | 15 | Gains, 5 bits per zone, zone 0 lowest |
| mode_val | output | 4 | Mode register |

## Verification
The bench goes after the places where the byte tracking can slip. It sends a break in the gap between a write command and its data; a decoder that kept the pending flag would store the next opcode as gain data and lose its pulse. It sends a character with a low stop slot and nonzero data; a receiver that accepted it, or skipped the wait for the line to return high, would fire a start pulse or misread the next frame. It also checks the exact clock on which the readback start bit appears and the bit order, so a design that is one cycle early or late, or sends the most significant bit first, is caught. Finally it checks the masking of the narrow registers and the zero answer for undefined addresses, which a decoder that stored the full byte or aliased addresses would get wrong.

// File: rtl/lscmd_pkg.sv
package lscmd_pkg;
  localparam int CHAR_W = 8;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] MODE_ADDR = 5'h1F;
  localparam logic [2:0] GRP_WRITE = 3'b010;
  localparam logic [2:0] GRP_READ  = 3'b011;

  localparam logic [7:0] OP_RESET        = 8'h1B;
  localparam logic [7:0] OP_START        = 8'h08;
  localparam logic [7:0] OP_SAMPLE       = 8'h10;
  localparam logic [7:0] OP_READ         = 8'h02;
  localparam logic [7:0] OP_ABORT        = 8'h19;
  localparam logic [7:0] OP_SMP_RD       = 8'h12;
  localparam logic [7:0] OP_SMP_RD_START = 8'h16;

  typedef struct packed {
    logic rst;
    logic start;
    logic sample;
    logic read;
    logic abort;
  } act_t;

  function automatic act_t decode_action(input logic [CHAR_W-1:0] b);
    act_t a;
    a = '0;
    case (b)
      OP_RESET:        a.rst = 1'b1;
      OP_START:        a.start = 1'b1;
      OP_SAMPLE:       a.sample = 1'b1;
      OP_READ:         a.read = 1'b1;
      OP_ABORT:        a.abort = 1'b1;
      OP_SMP_RD:       begin a.sample = 1'b1; a.read = 1'b1; end
      OP_SMP_RD_START: begin a.sample = 1'b1; a.read = 1'b1; a.start = 1'b1; end
      default:         a = '0;
    endcase
    return a;
  endfunction

  function automatic logic is_write_cmd(input logic [CHAR_W-1:0] b);
    return b[7:5] == GRP_WRITE;
  endfunction

  function automatic logic is_read_cmd(input logic [CHAR_W-1:0] b);
    return b[7:5] == GRP_READ;
  endfunction
endpackage

// File: rtl/lscmd_deframe.sv
module lscmd_deframe #(
  parameter int DW = 8
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          sdin,
  output logic          byte_vld,
  output logic [DW-1:0] byte_q,
  output logic          brk_det
);
  localparam int CW = $clog2(DW + 1);

  typedef enum logic [1:0] {S_HUNT, S_BITS, S_DRAIN} st_t;
  st_t           st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shr;

  // stop slot is reached once all data bits are in
  wire stop_slot = (st == S_BITS) && (cnt == CW'(DW));

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_HUNT;
      cnt      <= '0;
      shr      <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
      brk_det  <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      brk_det  <= 1'b0;
      case (st)
        S_HUNT: if (!sdin) begin
          st  <= S_BITS;
          cnt <= '0;
        end
        S_BITS: if (!stop_slot) begin
          shr <= {sdin, shr[DW-1:1]};
          cnt <= cnt + 1'b1;
        end else if (sdin) begin
          byte_vld <= 1'b1;
          byte_q   <= shr;
          st       <= S_HUNT;
        end else begin
          brk_det <= (shr == '0);
          st      <= S_DRAIN;
        end
        S_DRAIN: if (sdin) st <= S_HUNT;
        default: st <= S_HUNT;
      endcase
    end
  end

  // R1: a character is either delivered or taken as a break, never both
  a_r1_byte_or_break: assert property (@(posedge sclk) disable iff (!rst_n)
    !(byte_vld && brk_det));

  // R10: a low stop slot never yields a byte on the next cycle
  a_r10_bad_stop_dropped: assert property (@(posedge sclk) disable iff (!rst_n)
    (stop_slot && !sdin) |=> !byte_vld);
endmodule

// File: rtl/lscmd_decode.sv
module lscmd_decode
  import lscmd_pkg::*;
#(
  parameter int ZONES  = 3,
  parameter int OFS_W  = 8,
  parameter int GAIN_W = 5,
  parameter int MODE_W = 4
) (
  input  logic                    sclk,
  input  logic                    rst_n,
  input  logic                    byte_vld,
  input  logic [CHAR_W-1:0]       byte_d,
  input  logic                    brk,
  output act_t                    act,
  output logic [ZONES*OFS_W-1:0]  zone_ofs,
  output logic [ZONES*GAIN_W-1:0] zone_gain,
  output logic [MODE_W-1:0]       mode_val,
  output logic                    rd_go,
  output logic [CHAR_W-1:0]       rd_val
);
  localparam int NWE = 2 * ZONES + 1;

  logic              pending_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [OFS_W-1:0]  ofs_q  [ZONES];
  logic [GAIN_W-1:0] gain_q [ZONES];
  logic [MODE_W-1:0] mode_q;
  logic [NWE-1:0]    we;
  logic [CHAR_W-1:0] rd_mux;

  wire               wr_fire = byte_vld && pending_q;
  wire [ADDR_W-1:0]  cmd_addr = byte_d[ADDR_W-1:0];

  genvar z;
  generate
    for (z = 0; z < ZONES; z++) begin : g_zone
      assign we[2*z]   = wr_fire && (wr_addr_q == ADDR_W'(2*z));
      assign we[2*z+1] = wr_fire && (wr_addr_q == ADDR_W'(2*z+1));

      always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
          ofs_q[z]  <= '0;
          gain_q[z] <= '0;
        end else begin
          if (we[2*z])   ofs_q[z]  <= byte_d[OFS_W-1:0];
          if (we[2*z+1]) gain_q[z] <= byte_d[GAIN_W-1:0];
        end
      end

      assign zone_ofs[z*OFS_W +: OFS_W]    = ofs_q[z];
      assign zone_gain[z*GAIN_W +: GAIN_W] = gain_q[z];
    end
  endgenerate

  assign we[NWE-1] = wr_fire && (wr_addr_q == MODE_ADDR);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)         mode_q <= '0;
    else if (we[NWE-1]) mode_q <= byte_d[MODE_W-1:0];
  end
  assign mode_val = mode_q;

  // readback selection, zero for undefined addresses
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < ZONES; i++) begin
      if (cmd_addr == ADDR_W'(2*i))   rd_mux = CHAR_W'(ofs_q[i]);
      if (cmd_addr == ADDR_W'(2*i+1)) rd_mux = CHAR_W'(gain_q[i]);
    end
    if (cmd_addr == MODE_ADDR) rd_mux = CHAR_W'(mode_q);
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      wr_addr_q <= '0;
      act       <= '0;
      rd_go     <= 1'b0;
      rd_val    <= '0;
    end else begin
      act   <= '0;
      rd_go <= 1'b0;
      if (brk) begin
        pending_q <= 1'b0;
      end else if (byte_vld) begin
        if (pending_q) begin
          pending_q <= 1'b0;
        end else if (is_write_cmd(byte_d)) begin
          pending_q <= 1'b1;
          wr_addr_q <= cmd_addr;
        end else if (is_read_cmd(byte_d)) begin
          rd_go  <= 1'b1;
          rd_val <= rd_mux;
        end else begin
          act <= decode_action(byte_d);
        end
      end
    end
  end

  // R2: every action pulse is the answer to a byte delivered one cycle earlier
  a_r2_pulse_follows_byte: assert property (@(posedge sclk) disable iff (!rst_n)
    (|act) |-> $past(byte_vld));

  // R5: one data byte writes at most one register
  a_r5_single_target: assert property (@(posedge sclk) disable iff (!rst_n)
    $onehot0(we));

  // R9: a break leaves no write half-open
  a_r9_break_clears_pending: assert property (@(posedge sclk) disable iff (!rst_n)
    brk |=> !pending_q);

  // R8: a register read never raises an action pulse
  a_r8_read_silent: assert property (@(posedge sclk) disable iff (!rst_n)
    rd_go |-> !(|act));
endmodule

// File: rtl/lscmd_serial_out.sv
module lscmd_serial_out #(
  parameter int DW  = 8,
  parameter int LAT = 4
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] data,
  output logic          sdout,
  output logic          busy
);
  localparam int FW      = DW + 2;
  localparam int RW      = $clog2(FW + 1);
  localparam int WW      = $clog2(LAT + 1);
  localparam int WAIT_LD = LAT - 2;

  logic [FW-1:0] frame_q;
  logic [RW-1:0] rem_q;
  logic [WW-1:0] wait_q;
  logic          tx_bit;

  assign busy = (rem_q != '0);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      rem_q   <= '0;
      wait_q  <= '0;
      tx_bit  <= 1'b1;
    end else if (go) begin
      frame_q <= {1'b1, data, 1'b0};
      rem_q   <= RW'(FW);
      wait_q  <= WW'(WAIT_LD);
    end else if (busy) begin
      if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end else begin
        tx_bit  <= frame_q[0];
        frame_q <= {1'b1, frame_q[FW-1:1]};
        rem_q   <= rem_q - 1'b1;
      end
    end else begin
      tx_bit <= 1'b1;
    end
  end

  // the line changes half a cycle after the bit is chosen
  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) sdout <= 1'b1;
    else        sdout <= tx_bit;
  end

  // R8: readback requests only arrive while the serializer is free
  a_r8_go_when_idle: assert property (@(posedge sclk) disable iff (!rst_n)
    go |-> !busy);

  // R8: a request is always followed by a transfer in progress
  a_r8_go_starts_frame: assert property (@(posedge sclk) disable iff (!rst_n)
    go |=> busy);
endmodule

// File: rtl/scan_cmd_decoder.sv
module scan_cmd_decoder
  import lscmd_pkg::*;
#(
  parameter int ZONES  = 3,
  parameter int OFS_W  = 8,
  parameter int GAIN_W = 5,
  parameter int MODE_W = 4,
  parameter int RD_LAT = 4
) (
  input  logic                    sclk,
  input  logic                    rst_n,
  input  logic                    sdin,
  output logic                    sdout,
  output logic                    act_reset,
  output logic                    act_start,
  output logic                    act_sample,
  output logic                    act_read,
  output logic                    act_abort,
  output logic [ZONES*OFS_W-1:0]  zone_ofs,
  output logic [ZONES*GAIN_W-1:0] zone_gain,
  output logic [MODE_W-1:0]       mode_val
);
  logic              byte_vld;
  logic [CHAR_W-1:0] byte_q;
  logic              brk_det;
  act_t              act;
  logic              rd_go;
  logic [CHAR_W-1:0] rd_val;
  logic              tx_busy;

  lscmd_deframe #(.DW(CHAR_W)) u_rx (
    .sclk(sclk), .rst_n(rst_n), .sdin(sdin),
    .byte_vld(byte_vld), .byte_q(byte_q), .brk_det(brk_det)
  );

  lscmd_decode #(.ZONES(ZONES), .OFS_W(OFS_W), .GAIN_W(GAIN_W), .MODE_W(MODE_W)) u_dec (
    .sclk(sclk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_d(byte_q), .brk(brk_det),
    .act(act), .zone_ofs(zone_ofs), .zone_gain(zone_gain), .mode_val(mode_val),
    .rd_go(rd_go), .rd_val(rd_val)
  );

  lscmd_serial_out #(.DW(CHAR_W), .LAT(RD_LAT)) u_tx (
    .sclk(sclk), .rst_n(rst_n), .go(rd_go), .data(rd_val),
    .sdout(sdout), .busy(tx_busy)
  );

  assign act_reset  = act.rst;
  assign act_start  = act.start;
  assign act_sample = act.sample;
  assign act_read   = act.read;
  assign act_abort  = act.abort;

  // R11: sdout stays high whenever no readback frame is in flight
  a_r11_line_idle_high: assert property (@(posedge sclk) disable iff (!rst_n)
    (!tx_busy && !$past(tx_busy)) |-> sdout);
endmodule

// File: tb/scan_cmd_decoder_tb.sv
`timescale 1ns/1ps
module scan_cmd_decoder_tb;
  logic sclk = 1'b0;
  logic rst_n = 1'b0;
  logic sdin = 1'b1;
  logic sdout, act_reset, act_start, act_sample, act_read, act_abort;
  logic [23:0] zone_ofs;
  logic [14:0] zone_gain;
  logic [3:0]  mode_val;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_ofs [3];
  logic [4:0] m_gain [3];
  logic [3:0] m_mode;

  always #2 sclk = ~sclk;

  scan_cmd_decoder u_dut (
    .sclk(sclk), .rst_n(rst_n), .sdin(sdin), .sdout(sdout),
    .act_reset(act_reset), .act_start(act_start), .act_sample(act_sample),
    .act_read(act_read), .act_abort(act_abort),
    .zone_ofs(zone_ofs), .zone_gain(zone_gain), .mode_val(mode_val)
  );

  // {opcode, expected {reset,start,sample,read,abort}}
  localparam logic [12:0] VEC [12] = '{
    {8'h1B, 5'b10000}, {8'h08, 5'b01000}, {8'h10, 5'b00100}, {8'h02, 5'b00010},
    {8'h19, 5'b00001}, {8'h12, 5'b00110}, {8'h16, 5'b01110}, {8'h00, 5'b00000},
    {8'h1A, 5'b00000}, {8'h20, 5'b00000}, {8'h80, 5'b00000}, {8'hFF, 5'b00000}
  };

  function automatic logic [4:0] pulses();
    return {act_reset, act_start, act_sample, act_read, act_abort};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic send_char(input logic [7:0] b, input logic stop);
    for (int i = 0; i < 10; i++) begin
      @(negedge sclk);
      sdin = (i == 0) ? 1'b0 : (i == 9) ? stop : b[i-1];
    end
  endtask

  // from the stop-bit drive to just after the decode edge
  task automatic to_exec();
    @(posedge sclk);
    @(posedge sclk);
    #1;
  endtask

  task automatic idle(input int n);
    @(negedge sclk);
    sdin = 1'b1;
    repeat (n) @(negedge sclk);
  endtask

  task automatic check_regs(input string tag);
    for (int z = 0; z < 3; z++) begin
      chk({tag, " ofs"}, 32'(zone_ofs[z*8 +: 8]), 32'(m_ofs[z]));
      chk({tag, " gain"}, 32'(zone_gain[z*5 +: 5]), 32'(m_gain[z]));
    end
    chk({tag, " mode"}, 32'(mode_val), 32'(m_mode));
  endtask

  task automatic reg_write(input logic [4:0] addr, input logic [7:0] d);
    send_char(8'h40 | 8'(addr), 1'b1);
    idle(4);
    send_char(d, 1'b1);
    to_exec();
    idle(8);
  endtask

  task automatic reg_read(input logic [4:0] addr, input logic [7:0] exp_v, input string tag);
    logic [9:0] f;
    send_char(8'h60 | 8'(addr), 1'b1);
    to_exec();
    chk({tag, " R8 no pulse on read"}, 32'(pulses()), 32'h0);
    repeat (4) @(posedge sclk);
    #1;
    chk({tag, " R8 line still idle at E+4"}, 32'(sdout), 32'h1);
    for (int j = 0; j < 10; j++) begin
      @(posedge sclk);
      #1;
      f[j] = sdout;
    end
    chk({tag, " R8 start bit"}, 32'(f[0]), 32'h0);
    chk({tag, " R8 stop bit"}, 32'(f[9]), 32'h1);
    chk({tag, " data"}, 32'(f[8:1]), 32'(exp_v));
    @(posedge sclk);
    #1;
    chk({tag, " R8 idle after frame"}, 32'(sdout), 32'h1);
    idle(6);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int z = 0; z < 3; z++) begin m_ofs[z] = '0; m_gain[z] = '0; end
    m_mode = '0;
    repeat (3) @(negedge sclk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk("R11 pulses after reset", 32'(pulses()), 32'h0);
    chk("R11 sdout after reset", 32'(sdout), 32'h1);
    check_regs("R11");
    idle(12);

    // R5/R6 writes to every defined address
    reg_write(5'd0, 8'h85); m_ofs[0] = 8'h85;  check_regs("R5 ofs0");
    reg_write(5'd2, 8'h7F); m_ofs[1] = 8'h7F;  check_regs("R5 ofs1");
    reg_write(5'd4, 8'h01); m_ofs[2] = 8'h01;  check_regs("R5 ofs2");
    reg_write(5'd1, 8'hFF); m_gain[0] = 5'h1F; check_regs("R6 gain0 masked");
    reg_write(5'd3, 8'h0A); m_gain[1] = 5'h0A; check_regs("R5 gain1");
    reg_write(5'd5, 8'hF5); m_gain[2] = 5'h15; check_regs("R6 gain2 masked");
    reg_write(5'h1F, 8'hAB); m_mode = 4'hB;    check_regs("R6 mode masked");

    // R8 readback of each register
    reg_read(5'd0, 8'h85, "R5 read ofs0");
    reg_read(5'd2, 8'h7F, "R5 read ofs1");
    reg_read(5'd1, 8'h1F, "R6 read gain0");
    reg_read(5'd5, 8'h15, "R6 read gain2");
    reg_read(5'h1F, 8'h0B, "R6 read mode");

    // R7 undefined addresses
    reg_write(5'd7, 8'h55);  check_regs("R7 write addr7 ignored");
    reg_write(5'h1E, 8'h33); check_regs("R7 write addr1E ignored");
    reg_read(5'd6, 8'h00, "R7 read addr6");
    reg_read(5'h1E, 8'h00, "R7 read addr1E");

    // R1/R2/R3/R4 opcode table
    for (int k = 0; k < 12; k++) begin
      send_char(VEC[k][12:5], 1'b1);
      to_exec();
      chk($sformatf("R1 R2 R3 R4 opcode %02h pulses", VEC[k][12:5]), 32'(pulses()), 32'(VEC[k][4:0]));
      @(posedge sclk);
      #1;
      chk($sformatf("R2 opcode %02h one cycle", VEC[k][12:5]), 32'(pulses()), 32'h0);
      idle(8);
    end
    check_regs("R12 R4 registers kept after opcodes");

    // R9 break between write command and data
    send_char(8'h41, 1'b1);
    idle(4);
    send_char(8'h00, 1'b0);
    repeat (4) @(negedge sclk);
    idle(8);
    send_char(8'h08, 1'b1);
    to_exec();
    chk("R9 byte after break is a command", 32'(pulses()), 32'h08);
    idle(8);
    check_regs("R9 no write after break");

    // R10 low stop slot with nonzero data
    send_char(8'h08, 1'b0);
    to_exec();
    chk("R10 bad frame ignored", 32'(pulses()), 32'h0);
    repeat (3) @(negedge sclk);
    idle(8);
    send_char(8'h10, 1'b1);
    to_exec();
    chk("R10 next frame decoded", 32'(pulses()), 32'h04);
    idle(8);
    check_regs("R10 registers kept");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule